// File: doc/BRIEF.md
# Tunable Capacitor Serial Bus Master

This block is the host side of a three-wire write-only serial bus that programs a group of digitally tuned capacitor devices. A request carries a device mask and one 8-bit control word per device. The block turns it into framed serial transfers on a clock line (SCL), one or more data lines (SDA) and one or more enable lines (SEN). Every bus interval is a whole number of system clock cycles, set by a parameter, so that the device's minimum timing holds for the clock in use.

The way the devices share the bus is fixed at elaboration by `SHARED_EN`. With `SHARED_EN = 0`, SDA and SCL are common and each device has its own SEN. The devices are written one after another, and each one takes its new word when its own SEN falls. With `SHARED_EN = 1`, SEN and SCL are common and each device has its own SDA. All devices receive their words in one frame and update together.

Requests use a valid/ready handshake. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high, and `req_mask` and `req_words` are sampled only on that edge. `req_ready` is high only while the block is idle. A request held while `req_ready` is low waits and has no effect on the bus. Completion is reported on `busy` and `done`.

Top module: `captune_bus_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, SCL, every SDA line and every SEN line are low, `busy` is low and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high in the following cycle. `req_valid` asserted while `busy` is high causes no frame and changes no queued word.
- R3: Each frame carries exactly 8 bits, most significant bit first. One bit is sampled on each SCL rising edge. The word on the bus is the requested word with bits 6 and 5 cleared (bit 7 is standby, bits 4..0 are the state). SCL is high only while a SEN is high.
- R4: SDA changes only while SCL is low. SDA never changes during an SCL high phase.
- R5: Each SCL high phase and each SCL low phase between two bits lasts exactly `T_HALF` clock cycles. The default of 2 gives 40 ns at a 20 ns clock.
- R6: SEN is high at least `T_ESU` cycles before the first SCL rise. SEN stays high at least `T_HALF + T_EHD` cycles after the last SCL rise. With the defaults this is 20 ns and 60 ns.
- R7: Between the SEN fall of one frame and the SEN rise of the next, SEN stays low at least `T_EOW` cycles. The default is 2 cycles, or 40 ns.
- R8: With `SHARED_EN = 0`, each device whose mask bit is set gets one frame, in ascending device index. Only one SEN is high at a time. The SEN of a device whose mask bit is clear stays low for the whole request.
- R9: With `SHARED_EN = 1`, one frame carries every device's word at once on its own SDA line, device d on `sda[d]`, whatever the mask holds.
- R10: `done` is high for exactly one cycle, after the last SEN fall and its idle gap. `busy` is low in the cycle after `done`. An all-clear mask with `SHARED_EN = 0` produces no frame and still pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mask | input | N_DEV | Devices to write (used when SHARED_EN = 0) |
| req_words | input | 8*N_DEV | Control word of device d in bits 8d+7..8d |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| scl | output | 1 | Serial clock, idles low |
| sda | output | SHARED_EN ? N_DEV : 1 | Serial data line or lines |
| sen | output | SHARED_EN ? 1 : N_DEV | Enable line or lines |

## Verification
The embedded properties assume that `rst_n` is released synchronously. They also assume that `req_mask` and `req_words` matter only on the accepting edge, so the stimulus changes them only at falling clock edges and holds `req_valid` across exactly one rising edge when it is idle. The bench also raises `req_valid` with different data during a transfer to show that a busy block ignores it. Both sharing modes are built side by side and receive the same requests. A bus monitor for each mode decodes the frames and measures every interval in cycles. It then compares the decoded words against the words the driver queued.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP,
    ST_DONE
  } ctb_state_e;

  // Reserved positions 6 and 5 always travel as zero.
  function automatic logic [7:0] ctb_clean(input logic [7:0] w);
    return {w[7], 2'b00, w[4:0]};
  endfunction

endpackage

// File: rtl/ctb_tick.sv
module ctb_tick #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ctb_pick.sv
module ctb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest pending index wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ctb_lanes.sv
module ctb_lanes #(
  parameter int N         = 4,
  parameter int SHARED_EN = 0,
  parameter int IW        = 2,
  parameter int SDA_W     = 1,
  parameter int SEN_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_on,
  input  logic [8*N-1:0]   words,
  input  logic [2:0]       bit_idx,
  input  logic [IW-1:0]    cur,
  output logic [SDA_W-1:0] sda,
  output logic [SEN_W-1:0] sen
);
  generate
    if (SHARED_EN != 0) begin : g_common_en
      for (genvar d = 0; d < N; d++) begin : g_lane
        assign sda[d] = frame_on & words[8*d + int'(bit_idx)];
      end
      assign sen[0] = frame_on & (cur == '0);
    end else begin : g_common_data
      assign sda[0] = frame_on & words[{cur, bit_idx}];
      for (genvar d = 0; d < N; d++) begin : g_en
        assign sen[d] = frame_on & (cur == IW'(d));
      end

      a_r8_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sen))
        else $error("R8: more than one enable high");
    end
  endgenerate
endmodule

// File: rtl/captune_bus_master.sv
module captune_bus_master #(
  parameter int N_DEV     = 4,
  parameter int SHARED_EN = 0,
  parameter int T_HALF    = 2,
  parameter int T_ESU     = 1,
  parameter int T_EHD     = 1,
  parameter int T_EOW     = 2,
  localparam int SDA_W    = (SHARED_EN != 0) ? N_DEV : 1,
  localparam int SEN_W    = (SHARED_EN != 0) ? 1 : N_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [N_DEV-1:0]   req_mask,
  input  logic [8*N_DEV-1:0] req_words,
  output logic               busy,
  output logic               done,
  output logic               scl,
  output logic [SDA_W-1:0]   sda,
  output logic [SEN_W-1:0]   sen
);
  import ctb_pkg::*;

  localparam int IW    = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int TM_A  = (T_HALF > T_ESU) ? T_HALF : T_ESU;
  localparam int TM_B  = (T_EHD > T_EOW) ? T_EHD : T_EOW;
  localparam int TMAX  = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int TW    = $clog2(TMAX + 1);

  ctb_state_e           state, nxt;
  logic [N_DEV-1:0]     pend;
  logic [IW-1:0]        cur;
  logic [2:0]           bit_idx;
  logic [8*N_DEV-1:0]   words;
  logic                 tload, expired, found, frame_on;
  logic [TW-1:0]        tval;
  logic [IW-1:0]        pick_idx;

  ctb_tick #(.W(TW)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .expired(expired)
  );

  ctb_pick #(.N(N_DEV), .IW(IW)) u_pick (
    .pend(pend), .found(found), .idx(pick_idx)
  );

  always_comb begin
    nxt   = state;
    tload = 1'b0;
    tval  = '0;
    unique case (state)
      ST_IDLE:  if (req_valid) nxt = ST_PICK;
      ST_PICK:
        if (found) begin
          nxt = ST_SETUP; tload = 1'b1; tval = TW'(T_ESU - 1);
        end else begin
          nxt = ST_DONE;
        end
      ST_SETUP:
        if (expired) begin
          nxt = ST_HIGH; tload = 1'b1; tval = TW'(T_HALF - 1);
        end
      ST_HIGH:
        if (expired) begin
          tload = 1'b1;
          if (bit_idx == 3'd0) begin
            nxt = ST_HOLD; tval = TW'(T_EHD - 1);
          end else begin
            nxt = ST_LOW;  tval = TW'(T_HALF - 1);
          end
        end
      ST_LOW:
        if (expired) begin
          nxt = ST_HIGH; tload = 1'b1; tval = TW'(T_HALF - 1);
        end
      ST_HOLD:
        if (expired) begin
          nxt = ST_GAP; tload = 1'b1; tval = TW'(T_EOW - 1);
        end
      ST_GAP:   if (expired) nxt = ST_PICK;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend    <= '0;
      cur     <= '0;
      bit_idx <= '0;
      words   <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && req_valid) begin
        for (int d = 0; d < N_DEV; d++)
          words[8*d +: 8] <= ctb_clean(req_words[8*d +: 8]);
        pend <= (SHARED_EN != 0) ? N_DEV'(1) : req_mask;
      end
      if (state == ST_PICK && found) begin
        cur            <= pick_idx;
        pend[pick_idx] <= 1'b0;
        bit_idx        <= 3'd7;
      end
      if (state == ST_HIGH && expired && bit_idx != 3'd0)
        bit_idx <= bit_idx - 3'd1;
    end
  end

  assign frame_on  = (state == ST_SETUP) || (state == ST_HIGH) ||
                     (state == ST_LOW)   || (state == ST_HOLD);
  assign scl       = (state == ST_HIGH);
  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);

  ctb_lanes #(
    .N(N_DEV), .SHARED_EN(SHARED_EN), .IW(IW), .SDA_W(SDA_W), .SEN_W(SEN_W)
  ) u_lanes (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .words(words),
    .bit_idx(bit_idx), .cur(cur), .sda(sda), .sen(sen)
  );

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy)
    else $error("R2: accepted request did not raise busy");

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy))
    else $error("R10: done not a single pulse");

  a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl)) |-> $stable(sda))
    else $error("R4: data moved while clock high");

  a_r3_clock_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    scl |-> (|sen))
    else $error("R3: clock pulse outside a frame");

  a_r7_enable_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|sen) |=> !(|sen))
    else $error("R7: enable raised right after falling");
endmodule

// File: tb/test_captune_bus_master.sv
module ctb_bus_mon #(
  parameter int N         = 4,
  parameter int SHARED_EN = 0,
  parameter int T_HALF    = 2,
  parameter int T_ESU     = 1,
  parameter int T_EHD     = 1,
  parameter int T_EOW     = 2,
  localparam int SDA_W    = (SHARED_EN != 0) ? N : 1,
  localparam int SEN_W    = (SHARED_EN != 0) ? 1 : N
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl,
  input logic [SDA_W-1:0] sda,
  input logic [SEN_W-1:0] sen
);
  logic [15:0] q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic push(input int dev, input logic [7:0] w);
    q.push_back({dev[7:0], w});
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (mode %0d): actual %0d expected %0d", req, SHARED_EN, act, exp);
    end
  endtask

  logic             p_sen, p_scl;
  logic [SDA_W-1:0] p_sda;
  logic [7:0]       sh [SDA_W];
  int n_bits, since_sen, since_rise, hi_len, lo_len, gap, dev;
  bit seen_rise, had_frame, bad4, bad5;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sen = 0; p_scl = 0; p_sda = '0; had_frame = 0; gap = 0;
    end else begin
      if ((|sen) && !p_sen) begin
        n_bits = 0; since_sen = 0; since_rise = 0; hi_len = 0; lo_len = 0;
        seen_rise = 0; bad4 = 0; bad5 = 0;
        if (had_frame) chk(gap >= T_EOW, "R7 gap", gap, T_EOW);
        if (SHARED_EN == 0) begin
          chk($countones(sen) == 1, "R8 one enable", $countones(sen), 1);
          dev = 0;
          for (int d = 0; d < SEN_W; d++) if (sen[d]) dev = d;
        end
      end
      if (|sen) begin
        if (scl && !p_scl) begin
          if (!seen_rise) chk(since_sen >= T_ESU, "R6 setup", since_sen, T_ESU);
          else if (lo_len != T_HALF) bad5 = 1;
          seen_rise = 1;
          for (int d = 0; d < SDA_W; d++) sh[d] = {sh[d][6:0], sda[d]};
          n_bits++;
          since_rise = 0;
          hi_len = 0;
        end
        if (!scl && p_scl) begin
          if (hi_len != T_HALF) bad5 = 1;
          lo_len = 0;
        end
        if (scl && p_scl && sda != p_sda) bad4 = 1;
        if (scl) hi_len++; else lo_len++;
        if (!seen_rise) since_sen++;
        since_rise++;
      end
      if (!(|sen) && p_sen) begin
        chk(n_bits == 8, "R3 bit count", n_bits, 8);
        chk(since_rise >= T_HALF + T_EHD, "R6 hold", since_rise, T_HALF + T_EHD);
        chk(!bad4, "R4 data steady", int'(bad4), 0);
        chk(!bad5, "R5 clock phases", int'(bad5), 0);
        for (int d = 0; d < SDA_W; d++) begin
          if (q.size() == 0) begin
            chk(0, "R2 unexpected frame", int'(sh[d]), -1);
          end else begin
            logic [15:0] e;
            e = q.pop_front();
            if (SHARED_EN != 0)
              chk(int'(e[15:8]) == d && e[7:0] == sh[d], "R9 lane word",
                  int'(sh[d]), int'(e[7:0]));
            else
              chk(int'(e[15:8]) == dev && e[7:0] == sh[d], "R8 device word",
                  dev * 256 + int'(sh[d]), int'(e[15:0]));
          end
        end
        had_frame = 1;
        gap = 0;
      end
      if (!(|sen)) gap++;
      p_sen = |sen; p_scl = scl; p_sda = sda;
    end
  end
endmodule

module test_captune_bus_master;
  localparam int N = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [N-1:0] req_mask = '0;
  logic [8*N-1:0] req_words = '0;

  logic rdy_sd, busy_sd, done_sd, scl_sd, sda_sd;
  logic [N-1:0] sen_sd;
  logic rdy_se, busy_se, done_se, scl_se, sen_se;
  logic [N-1:0] sda_se;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  captune_bus_master #(.N_DEV(N), .SHARED_EN(0)) i_captune_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_sd),
    .req_mask(req_mask), .req_words(req_words), .busy(busy_sd), .done(done_sd),
    .scl(scl_sd), .sda(sda_sd), .sen(sen_sd)
  );

  captune_bus_master #(.N_DEV(N), .SHARED_EN(1)) i_captune_bus_master_se (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_se),
    .req_mask(req_mask), .req_words(req_words), .busy(busy_se), .done(done_se),
    .scl(scl_se), .sda(sda_se), .sen(sen_se)
  );

  ctb_bus_mon #(.N(N), .SHARED_EN(0)) m_sd (
    .clk(clk), .rst_n(rst_n), .scl(scl_sd), .sda(sda_sd), .sen(sen_sd));
  ctb_bus_mon #(.N(N), .SHARED_EN(1)) m_se (
    .clk(clk), .rst_n(rst_n), .scl(scl_se), .sda(sda_se), .sen(sen_se));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    int tot, bad;
    tot = n_chk + m_sd.n_chk + m_se.n_chk;
    bad = n_bad + m_sd.n_bad + m_se.n_bad;
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
    end
  end

  task automatic send(input logic [N-1:0] m, input logic [8*N-1:0] w, input bit poke);
    bit seen_sd, seen_se, pend_sd, pend_se;
    int guard;
    chk(rdy_sd && rdy_se, "R2 ready when idle", int'({rdy_sd, rdy_se}), 3);
    for (int d = 0; d < N; d++) begin
      if (m[d]) m_sd.push(d, w[8*d +: 8] & 8'h9F);
      m_se.push(d, w[8*d +: 8] & 8'h9F);
    end
    req_mask = m; req_words = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy_sd && busy_se, "R2 busy after accept", int'({busy_sd, busy_se}), 3);
    if (poke) begin
      req_mask = '1; req_words = '1; req_valid = 1;
      for (int i = 0; i < 8; i++) @(negedge clk);
      req_valid = 0;
    end
    seen_sd = 0; seen_se = 0; pend_sd = 0; pend_se = 0; guard = 0;
    while (!(seen_sd && seen_se) && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (pend_sd) begin
        chk(!done_sd && !busy_sd, "R10 done pulse sd", int'({done_sd, busy_sd}), 0);
        pend_sd = 0; seen_sd = 1;
      end else if (done_sd && !seen_sd) begin
        chk(m_sd.q.size() == 0, "R10 frames before done sd", m_sd.q.size(), 0);
        chk(sen_sd == '0, "R8 idle enables", int'(sen_sd), 0);
        pend_sd = 1;
      end
      if (pend_se) begin
        chk(!done_se && !busy_se, "R10 done pulse se", int'({done_se, busy_se}), 0);
        pend_se = 0; seen_se = 1;
      end else if (done_se && !seen_se) begin
        chk(m_se.q.size() == 0, "R10 frames before done se", m_se.q.size(), 0);
        pend_se = 1;
      end
    end
    chk(seen_sd && seen_se, "R10 done seen", int'({seen_sd, seen_se}), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!scl_sd && !sda_sd && sen_sd == '0, "R1 idle bus sd",
        int'({scl_sd, sda_sd, sen_sd}), 0);
    chk(!scl_se && sda_se == '0 && !sen_se, "R1 idle bus se",
        int'({scl_se, sda_se, sen_se}), 0);
    chk(!busy_sd && !busy_se && !done_sd && !done_se, "R1 not busy",
        int'({busy_sd, busy_se, done_sd, done_se}), 0);
    chk(rdy_sd && rdy_se, "R1 ready", int'({rdy_sd, rdy_se}), 3);

    send(4'b1011, 32'hFF12_A53C, 0);                 // R3 R8 skipped device 2
    send(4'b1000, 32'h6E00_0000, 0);                 // R8 single top device
    send(4'b0000, 32'h8081_8283, 0);                 // R10 empty mask, R9 mask ignored
    send(4'b1111, 32'hE060_1F80, 1);                 // R2 poke while busy, R3 reserved bits
    send(4'b0101, 32'h0000_FFFF, 0);                 // R3 R9 mixed patterns

    repeat (60) @(negedge clk);
    chk(m_sd.q.size() == 0 && m_se.q.size() == 0, "R2 no leftover frames",
        m_sd.q.size() + m_se.q.size(), 0);
    chk(!busy_sd && !busy_se && !scl_sd && !scl_se && sen_sd == '0 && !sen_se,
        "R1 idle after requests", int'({busy_sd, busy_se}), 0);
    summary();
  end
endmodule